// File: doc/BRIEF.md
# Floating-Point Compare Unit with Condition Codes

This unit compares two IEEE-754 operands, held either in binary64 or in binary32 form, and produces a four-flag condition code that classifies the pair. The flags are unordered, less, greater and equal. Before the compare, any subnormal operand is flushed to zero. The only rounding mode is round-to-nearest, so no rounding control is needed. Signalling NaNs take their own exception path. When the invalid-operation enable is set, such a compare raises an invalid cause and leaves the code empty. When the enable is clear, the compare reports unordered.

A caller presents both operands, the precision select and the invalid enable, then pulses `start_i` for one cycle. On the next cycle the result appears, registered, along with a one-cycle `done_o`. The code and cause then hold until the next start. Each start first wipes out the previous code and cause. Starts may come back to back.

Top module: `fpcmp_unit`

## Requirements
- R1: While reset is asserted and after it is released, `fcc_o` is 0000, `inv_cause_o` is 0 and `done_o` is 0 until the first start.
- R2: A start in cycle N gives `done_o`=1 in cycle N+1 only, along with the new result. Without a start, `fcc_o` and `inv_cause_o` keep their values.
- R3: `fcc_o` bit 3 is unordered, bit 2 is less, bit 1 is greater and bit 0 is equal. After any compare that does not trap, exactly one bit is set.
- R4: Finite, non-NaN operands give less when A < B, greater when A > B and equal when A = B. This holds for both signs and in both precisions. With `dbl_i`=0, the operands are bits [31:0] and bits [63:32] have no effect.
- R5: Positive zero and negative zero compare equal.
- R6: An operand whose exponent field is all zeros is treated as zero. A subnormal therefore equals zero of either sign, and it is less than the smallest positive normal.
- R7: Infinities of the same sign compare equal. Negative infinity is less than every finite value, and positive infinity is greater than every finite value.
- R8: A quiet NaN is an operand with exponent all ones and the fraction MSB set. If one is present and no signalling NaN is, the result is unordered with cause 0, whatever the enable.
- R9: A signalling NaN is an operand with exponent all ones, fraction MSB clear and a nonzero fraction. With `inv_en_i`=1, either operand being one gives `inv_cause_o`=1 and `fcc_o`=0000. This takes priority over a quiet NaN in the other operand.
- R10: A signalling NaN with `inv_en_i`=0 gives unordered, and `inv_cause_o` stays 0.
- R11: Each compare clears the earlier cause and code. A normal compare that follows a trapped one reports cause 0 and its own code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to compare |
| dbl_i | input | 1 | 1 = binary64, 0 = binary32 in bits [31:0] |
| inv_en_i | input | 1 | Invalid-operation trap enable |
| opa_i | input | 64 | First operand A |
| opb_i | input | 64 | Second operand B |
| fcc_o | output | 4 | Condition code {U, L, G, E} |
| inv_cause_o | output | 1 | Invalid-operation cause |
| done_o | output | 1 | Result valid pulse |

## Verification
Pairs of finite values are applied in both sign orders, both negative, and equal. Together these separate a plain magnitude compare from a correct sign-magnitude one. Signed zeros, subnormals against zero and against the smallest normal, and infinities against each other and against finite values each target one ordering rule. Binary32 vectors carry junk in the upper word, which shows that the precision mux ignores it. NaN vectors combine quiet and signalling operands with the enable on and off. This exposes which path has priority and whether the trap is gated. A normal compare placed after a trap confirms that each start clears the previous cause.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
    // Format geometry
    parameter int unsigned OPW      = 64;
    parameter int unsigned D_EXPW   = 11;
    parameter int unsigned D_FRACW  = 52;
    parameter int unsigned S_EXPW   = 8;
    parameter int unsigned S_FRACW  = 23;
    localparam int unsigned MAGW    = D_EXPW + D_FRACW;      // 63
    localparam int unsigned S_MAGW  = S_EXPW + S_FRACW;      // 31
    localparam int unsigned S_W     = S_MAGW + 1;            // 32

    // Condition code bit positions
    localparam int unsigned FCC_W   = 4;
    localparam int unsigned FCC_U   = 3;
    localparam int unsigned FCC_L   = 2;
    localparam int unsigned FCC_G   = 1;
    localparam int unsigned FCC_E   = 0;

    typedef struct packed {
        logic            nan;
        logic            snan;
        logic            sgn;
        logic [MAGW-1:0] mag;   // zero when flushed
    } opnd_t;

    typedef struct packed {
        logic [FCC_W-1:0] fcc;
        logic             inv;
        logic             done;
    } cmp_state_t;
endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify
    import fpcmp_pkg::*;
(
    input  logic [OPW-1:0] op_i,
    input  logic           dbl_i,
    output opnd_t          info_o
);
    logic [D_EXPW-1:0]  d_exp;
    logic [D_FRACW-1:0] d_frac;
    logic [S_EXPW-1:0]  s_exp;
    logic [S_FRACW-1:0] s_frac;

    assign d_exp  = op_i[OPW-2 -: D_EXPW];
    assign d_frac = op_i[D_FRACW-1:0];
    assign s_exp  = op_i[S_W-2 -: S_EXPW];
    assign s_frac = op_i[S_FRACW-1:0];

    always_comb begin
        info_o = '0;
        if (dbl_i) begin
            info_o.sgn  = op_i[OPW-1];
            info_o.nan  = (&d_exp) && (|d_frac);
            info_o.snan = info_o.nan && !d_frac[D_FRACW-1];
            info_o.mag  = (d_exp == '0) ? '0 : op_i[MAGW-1:0];
        end else begin
            info_o.sgn  = op_i[S_W-1];
            info_o.nan  = (&s_exp) && (|s_frac);
            info_o.snan = info_o.nan && !s_frac[S_FRACW-1];
            info_o.mag  = (s_exp == '0) ? '0 :
                          {{(MAGW-S_MAGW){1'b0}}, op_i[S_MAGW-1:0]};
        end
    end
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
    import fpcmp_pkg::*;
(
    input  opnd_t a_i,
    input  opnd_t b_i,
    output logic  lt_o,
    output logic  gt_o,
    output logic  eq_o
);
    logic za, zb, sa, sb, mag_lt, mag_eq;

    assign za     = (a_i.mag == '0);
    assign zb     = (b_i.mag == '0);
    assign sa     = a_i.sgn & ~za;   // zero carries no sign
    assign sb     = b_i.sgn & ~zb;
    assign mag_lt = (a_i.mag < b_i.mag);
    assign mag_eq = (a_i.mag == b_i.mag);

    always_comb begin
        lt_o = 1'b0;
        gt_o = 1'b0;
        eq_o = 1'b0;
        if (za && zb) begin
            eq_o = 1'b1;
        end else if (sa != sb) begin
            lt_o = sa;
            gt_o = ~sa;
        end else if (mag_eq) begin
            eq_o = 1'b1;
        end else if (!sa) begin
            lt_o = mag_lt;
            gt_o = ~mag_lt;
        end else begin
            lt_o = ~mag_lt;
            gt_o = mag_lt;
        end
    end
endmodule

// File: rtl/fpcmp_unit.sv
module fpcmp_unit
    import fpcmp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             dbl_i,
    input  logic             inv_en_i,
    input  logic [OPW-1:0]   opa_i,
    input  logic [OPW-1:0]   opb_i,
    output logic [FCC_W-1:0] fcc_o,
    output logic             inv_cause_o,
    output logic             done_o
);
    localparam int unsigned NOPS = 2;

    logic [OPW-1:0] ops [NOPS];
    opnd_t          info [NOPS];
    logic           lt, gt, eq;
    logic           any_snan, any_nan;
    cmp_state_t     st_d, st_q;

    assign ops[0] = opa_i;
    assign ops[1] = opb_i;

    for (genvar gi = 0; gi < NOPS; gi++) begin : g_cls
        fpcmp_classify u_cls (
            .op_i   (ops[gi]),
            .dbl_i  (dbl_i),
            .info_o (info[gi])
        );
    end

    fpcmp_order u_ord (
        .a_i  (info[0]),
        .b_i  (info[1]),
        .lt_o (lt),
        .gt_o (gt),
        .eq_o (eq)
    );

    assign any_snan = info[0].snan | info[1].snan;
    assign any_nan  = info[0].nan  | info[1].nan;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (start_i) begin
            st_d.fcc  = '0;
            st_d.inv  = 1'b0;
            st_d.done = 1'b1;
            if (any_snan) begin
                if (inv_en_i) st_d.inv         = 1'b1;
                else          st_d.fcc[FCC_U]  = 1'b1;
            end else if (any_nan) begin
                st_d.fcc[FCC_U] = 1'b1;
            end else begin
                st_d.fcc[FCC_L] = lt;
                st_d.fcc[FCC_G] = gt;
                st_d.fcc[FCC_E] = eq;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fcc_o       = st_q.fcc;
    assign inv_cause_o = st_q.inv;
    assign done_o      = st_q.done;
endmodule

// File: rtl/fpcmp_unit_chk.sv
module fpcmp_unit_chk
    import fpcmp_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             dbl_i,
    input logic             inv_en_i,
    input logic [OPW-1:0]   opa_i,
    input logic [OPW-1:0]   opb_i,
    input logic [FCC_W-1:0] fcc_o,
    input logic             inv_cause_o,
    input logic             done_o
);
    always_comb begin
        if (!rst_n) begin
            AST_RESET_CLEAR: assert (fcc_o == '0 && !inv_cause_o && !done_o); // R1
        end
    end

    AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o); // R2
    AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !done_o); // R2
    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> ($stable(fcc_o) && $stable(inv_cause_o))); // R2
    AST_CODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !inv_cause_o) |-> ($countones(fcc_o) == 1)); // R3
    AST_ZEROS_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && dbl_i && opa_i[OPW-2:0] == '0 && opb_i[OPW-2:0] == '0)
        |=> (fcc_o == 4'b0001)); // R5
    AST_SUBNORMAL_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && dbl_i && opa_i[OPW-2 -: D_EXPW] == '0 && opb_i[OPW-2:0] == '0)
        |=> (fcc_o == 4'b0001)); // R6
    AST_TRAP_EMPTY_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        inv_cause_o |-> (fcc_o == '0)); // R9
    AST_SNAN_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && inv_en_i && dbl_i && (&opa_i[OPW-2 -: D_EXPW])
         && !opa_i[D_FRACW-1] && (|opa_i[D_FRACW-2:0]))
        |=> inv_cause_o); // R9
    AST_NO_TRAP_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !inv_en_i) |=> !inv_cause_o); // R10
endmodule

bind fpcmp_unit fpcmp_unit_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .dbl_i       (dbl_i),
    .inv_en_i    (inv_en_i),
    .opa_i       (opa_i),
    .opb_i       (opb_i),
    .fcc_o       (fcc_o),
    .inv_cause_o (inv_cause_o),
    .done_o      (done_o)
);

// File: tb/fpcmp_unit_tb_top.sv
module fpcmp_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] CU = 4'b1000, CL = 4'b0100, CG = 4'b0010, CE = 4'b0001, CN = 4'b0000;

    // binary64 constants
    localparam logic [63:0] D_P1   = 64'h3FF0000000000000;
    localparam logic [63:0] D_P2   = 64'h4000000000000000;
    localparam logic [63:0] D_M1   = 64'hBFF0000000000000;
    localparam logic [63:0] D_M2   = 64'hC000000000000000;
    localparam logic [63:0] D_PZ   = 64'h0000000000000000;
    localparam logic [63:0] D_MZ   = 64'h8000000000000000;
    localparam logic [63:0] D_PINF = 64'h7FF0000000000000;
    localparam logic [63:0] D_MINF = 64'hFFF0000000000000;
    localparam logic [63:0] D_QNAN = 64'h7FF8000000000000;
    localparam logic [63:0] D_SNAN = 64'h7FF0000000000001;
    localparam logic [63:0] D_SUB  = 64'h0000000000000001;
    localparam logic [63:0] D_MSUB = 64'h8000000000000001;
    localparam logic [63:0] D_MINN = 64'h0010000000000000;
    // binary32 constants with junk in the upper word
    localparam logic [63:0] S_P1   = 64'hDEADBEEF3F800000;
    localparam logic [63:0] S_P2   = 64'h1234567840000000;
    localparam logic [63:0] S_M1   = 64'hFFFFFFFFBF800000;
    localparam logic [63:0] S_M2   = 64'h7FF80000C0000000;
    localparam logic [63:0] S_MZ   = 64'hA5A5A5A580000000;
    localparam logic [63:0] S_PZ   = 64'h7FF0000100000000;
    localparam logic [63:0] S_SUB  = 64'h0000000100000001;
    localparam logic [63:0] S_MINF = 64'h00000000FF800000;
    localparam logic [63:0] S_QNAN = 64'h3FF000007FC00000;
    localparam logic [63:0] S_SNAN = 64'h000000007F800001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        dbl_i = 1'b0;
    logic        inv_en_i = 1'b0;
    logic [63:0] opa_i = '0;
    logic [63:0] opb_i = '0;
    logic [3:0]  fcc_o;
    logic        inv_cause_o;
    logic        done_o;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    finished = 1'b0;
    logic [4:0] exp_q [$];
    string      tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fpcmp_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dbl_i(dbl_i),
        .inv_en_i(inv_en_i), .opa_i(opa_i), .opb_i(opb_i),
        .fcc_o(fcc_o), .inv_cause_o(inv_cause_o), .done_o(done_o)
    );

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: got fcc/inv=%b expected %b", req, act, expv);
        end
    endtask

    // driver: applies one compare and queues its expected result
    task automatic cmp(input string req, input logic dbl, input logic en,
                       input logic [63:0] a, input logic [63:0] b,
                       input logic [3:0] efcc, input logic einv);
        @(negedge clk);
        start_i  = 1'b1;
        dbl_i    = dbl;
        inv_en_i = en;
        opa_i    = a;
        opb_i    = b;
        exp_q.push_back({efcc, einv});
        tag_q.push_back(req);
        @(negedge clk);
        start_i = 1'b0;
        opa_i   = '0;
        opb_i   = '0;
    endtask

    // monitor: pops the scoreboard on every done
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done_o) begin
                if (exp_q.size() == 0) begin
                    check("R2 unexpected done", {fcc_o, inv_cause_o}, 5'bxxxxx);
                end else begin
                    logic [4:0] e;
                    string      t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(t, {fcc_o, inv_cause_o}, e);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {fcc_o, inv_cause_o}, 5'b00000);
        check("R1 reset done", {4'b0, done_o}, 5'b00000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 after release", {fcc_o, inv_cause_o | done_o}, 5'b00000);

        // R4 finite ordering
        cmp("R4 d 1<2",      1, 0, D_P1, D_P2, CL, 0);
        cmp("R4 d 2>1",      1, 0, D_P2, D_P1, CG, 0);
        cmp("R4 d -1<1",     1, 0, D_M1, D_P1, CL, 0);
        cmp("R4 d -2<-1",    1, 0, D_M2, D_M1, CL, 0);
        cmp("R4 d 1==1",     1, 0, D_P1, D_P1, CE, 0);
        cmp("R4 s 1<2",      0, 0, S_P1, S_P2, CL, 0);
        cmp("R4 s -1>-2",    0, 0, S_M1, S_M2, CG, 0);
        cmp("R4 s 1==1 upper differs", 0, 0, S_P1, {32'h0, S_P1[31:0]}, CE, 0);
        // R5 signed zeros
        cmp("R5 d +0==-0",   1, 0, D_PZ, D_MZ, CE, 0);
        cmp("R5 s -0==+0",   0, 0, S_MZ, S_PZ, CE, 0);
        // R6 subnormal flush
        cmp("R6 d sub==0",   1, 0, D_SUB, D_PZ, CE, 0);
        cmp("R6 d -sub==+0", 1, 0, D_MSUB, D_PZ, CE, 0);
        cmp("R6 d sub<minnorm", 1, 0, D_SUB, D_MINN, CL, 0);
        cmp("R6 s sub==-0",  0, 0, S_SUB, S_MZ, CE, 0);
        // R7 infinities
        cmp("R7 d +inf==+inf", 1, 0, D_PINF, D_PINF, CE, 0);
        cmp("R7 d -inf==-inf", 1, 0, D_MINF, D_MINF, CE, 0);
        cmp("R7 d -inf<-2",    1, 0, D_MINF, D_M2, CL, 0);
        cmp("R7 d +inf>2",     1, 0, D_PINF, D_P2, CG, 0);
        cmp("R7 s -inf<1",     0, 0, S_MINF, S_P1, CL, 0);
        // R8 quiet NaN
        cmp("R8 d qnan en",    1, 1, D_QNAN, D_P1, CU, 0);
        cmp("R8 s qnan dis",   0, 0, S_P1, S_QNAN, CU, 0);
        // R9 signalling NaN trapped
        cmp("R9 d snan en",    1, 1, D_SNAN, D_P1, CN, 1);
        cmp("R9 s qnan+snan",  0, 1, S_QNAN, S_SNAN, CN, 1);
        // R11 clean after trap
        cmp("R11 after trap",  1, 1, D_P2, D_P1, CG, 0);
        // R10 signalling NaN not trapped
        cmp("R10 d snan dis",  1, 0, D_P1, D_SNAN, CU, 0);
        cmp("R9 b snan en",    1, 1, D_P1, D_SNAN, CN, 1);
        cmp("R10 s snan dis",  0, 0, S_SNAN, S_P1, CU, 0);

        // R2 hold: after idle cycles the last result must remain
        repeat (4) @(negedge clk);
        check("R2 hold", {fcc_o, inv_cause_o}, {CU, 1'b0});
        check("R2 done low idle", {4'b0, done_o}, 5'b00000);

        // back-to-back starts
        @(negedge clk);
        start_i = 1'b1; dbl_i = 1'b1; inv_en_i = 1'b0; opa_i = D_M1; opb_i = D_M2;
        exp_q.push_back({CG, 1'b0}); tag_q.push_back("R2 b2b first");
        @(negedge clk);
        opa_i = D_MZ; opb_i = D_PZ;
        exp_q.push_back({CE, 1'b0}); tag_q.push_back("R2 b2b second");
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        check("R2 queue drained", {4'b0, exp_q.size() == 0}, 5'b00001);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule